// File: doc/BRIEF.md
# Byte-Lane Steering Memory Bridge

The bridge sits between a core that reads and writes single bytes or 16-bit words at any byte address and a 16-bit synchronous memory bus. The bus has two byte lanes. The lower lane, data bits 7:0, carries bytes at even addresses. The upper lane, data bits 15:8, carries bytes at odd addresses. The bridge picks the lane enables, puts each byte on its lane and gathers read bytes back into place. The address space is 20 bits of byte addresses. Words are little-endian: the low byte is stored at the lower address.

A word at an even address moves in one bus cycle. A word at an odd address needs two bus cycles. The first cycle moves the word's low byte on the upper lane at the requested address. The second cycle moves the high byte on the lower lane at the next address. The bridge joins the two halves into one word. Each bus cycle lasts until the memory raises its ready input.

The core holds a request with its attributes steady until it sees a one-cycle acknowledge. After the acknowledge it drops the request.

Top module: `mem_lane_bridge`

## Requirements
- R1: While reset is asserted and right after it is released, `ack_o` is 0, `bus_req_o` is 0 and `bus_be_o` is 2'b00.
- R2: `bus_be_o[0]` enables the lower lane (bits 7:0) and `bus_be_o[1]` enables the upper lane (bits 15:8). A single-cycle access drives `bus_addr_o` equal to the request address. The enables are 2'b01 for an even byte, 2'b10 for an odd byte and 2'b11 for an even word.
- R3: A word request at an odd address A makes exactly two bus cycles, back to back. The first has address A and enables 2'b10. The second has address A+1 and enables 2'b01. The increment wraps 20'hFFFFF to 20'h00000.
- R4: A byte read returns the byte from the enabled lane in `rdata_o[7:0]` and zero in `rdata_o[15:8]`. The unenabled lane has no effect on the result.
- R5: A word read returns the byte at the lower address in `rdata_o[7:0]` and the byte at the next address in `rdata_o[15:8]`. For an odd address these come from the upper lane of the first cycle and the lower lane of the second cycle.
- R6: On writes, each enabled lane carries the correct byte of `wdata_i`. An even word drives `wdata_i` unchanged. In every other cycle the byte being written appears on both lanes.
- R7: While `bus_req_o` is high and `bus_ready_i` is low, `bus_addr_o`, `bus_be_o`, `bus_we_o` and `bus_wdata_o` hold their values. A bus cycle ends only at a clock edge where `bus_ready_i` is high.
- R8: `ack_o` is a one-cycle pulse. It rises in the cycle after the final bus cycle completes, never while `bus_req_o` is high, and `rdata_o` is valid while it is high. With a ready delay of w cycles on each bus cycle, `ack_o` appears (1+w) cycles per bus cycle plus one cycle after the request is first sampled.
- R9: With no bus cycle in progress, `bus_be_o` is 2'b00 and `bus_we_o` is 0. During a bus cycle `bus_we_o` equals the request's write flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Core request, held until acknowledged |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | 1 = 16-bit word, 0 = byte |
| addr_i | input | 20 | Byte address |
| wdata_i | input | 16 | Write data, byte in bits 7:0 for byte writes |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read result, valid with ack_o |
| bus_req_o | output | 1 | Bus cycle active |
| bus_we_o | output | 1 | Bus cycle is a write |
| bus_addr_o | output | 20 | Byte address of the bus cycle |
| bus_be_o | output | 2 | Lane enables, bit 0 lower lane, bit 1 upper lane |
| bus_wdata_o | output | 16 | Bus write data |
| bus_rdata_i | input | 16 | Bus read data |
| bus_ready_i | input | 1 | Memory completes the cycle when high |

## Verification
A wrong sequencer state shows up at the bus on the next cycle. It appears as a missing or extra second cycle, a second cycle with the wrong address or enables, or an acknowledge that comes early, late or twice, so the latency check catches it within one transaction. A wrong capture in the read merge shows up only in `rdata_o` at the acknowledge. The bench makes the two lanes of every memory word carry different, address-dependent bytes, so a lane swap or a dropped half changes the returned value. A wrong wrap of the second address shows up at the bus address of the second cycle of an odd word at the top of the address space.

// File: rtl/mem_lane_pkg.sv
package mem_lane_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/mem_lane_seq.sv
module mem_lane_seq
  import mem_lane_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic split_i,
  input  logic bus_ready_i,
  output logic latch_o,
  output logic second_o,
  output logic bus_req_o,
  output logic cap_o,
  output logic ack_o
);
  seq_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = ST_LO;
      ST_LO:   if (bus_ready_i) state_d = split_i ? ST_HI : ST_DONE;
      ST_HI:   if (bus_ready_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign latch_o   = (state_q == ST_IDLE) && req_i;
  assign second_o  = (state_q == ST_HI);
  assign bus_req_o = (state_q == ST_LO) || (state_q == ST_HI);
  assign cap_o     = bus_req_o && bus_ready_i;
  assign ack_o     = (state_q == ST_DONE);
endmodule

// File: rtl/mem_lane_steer.sv
module mem_lane_steer #(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input  logic                  active_i,
  input  logic                  second_i,
  input  logic                  we_i,
  input  logic                  word_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [2*LANE_W-1:0]   wdata_i,
  output logic [ADDR_W-1:0]     bus_addr_o,
  output logic [1:0]            bus_be_o,
  output logic                  bus_we_o,
  output logic [2*LANE_W-1:0]   bus_wdata_o
);
  localparam int DW = 2 * LANE_W;

  logic            odd;
  logic [LANE_W-1:0] lo_b, hi_b;

  assign odd  = addr_i[0];
  assign lo_b = wdata_i[LANE_W-1:0];
  assign hi_b = wdata_i[DW-1:LANE_W];

  // second cycle of a split word targets the next byte, wrapping at the top
  assign bus_addr_o = second_i ? addr_i + ADDR_W'(1) : addr_i;
  assign bus_we_o   = active_i && we_i;

  always_comb begin
    if (!active_i)     bus_be_o = 2'b00;
    else if (second_i) bus_be_o = 2'b01;
    else               bus_be_o = {odd | word_i, ~odd};
  end

  always_comb begin
    if (second_i)             bus_wdata_o = {hi_b, hi_b};
    else if (word_i && !odd)  bus_wdata_o = wdata_i;
    else                      bus_wdata_o = {lo_b, lo_b};
  end
endmodule

// File: rtl/mem_lane_merge.sv
module mem_lane_merge #(
  parameter int LANE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_i,
  input  logic                second_i,
  input  logic                we_i,
  input  logic                word_i,
  input  logic                odd_i,
  input  logic [2*LANE_W-1:0] bus_rdata_i,
  output logic [2*LANE_W-1:0] rdata_o
);
  localparam int DW = 2 * LANE_W;

  logic [LANE_W-1:0] lo_lane, hi_lane;
  logic [DW-1:0]     rd_q;

  assign lo_lane = bus_rdata_i[LANE_W-1:0];
  assign hi_lane = bus_rdata_i[DW-1:LANE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
    end else if (cap_i && !we_i) begin
      if (second_i)            rd_q[DW-1:LANE_W]   <= lo_lane;
      else if (word_i && !odd_i) rd_q              <= bus_rdata_i;
      else if (odd_i)          rd_q                <= {{LANE_W{1'b0}}, hi_lane};
      else                     rd_q                <= {{LANE_W{1'b0}}, lo_lane};
    end
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/mem_lane_bridge.sv
module mem_lane_bridge #(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic                word_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [2*LANE_W-1:0] wdata_i,
  output logic                ack_o,
  output logic [2*LANE_W-1:0] rdata_o,
  output logic                bus_req_o,
  output logic                bus_we_o,
  output logic [ADDR_W-1:0]   bus_addr_o,
  output logic [1:0]          bus_be_o,
  output logic [2*LANE_W-1:0] bus_wdata_o,
  input  logic [2*LANE_W-1:0] bus_rdata_i,
  input  logic                bus_ready_i
);
  localparam int DW = 2 * LANE_W;

  logic              latch, second, cap;
  logic              we_q, word_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      word_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (latch) begin
      we_q    <= we_i;
      word_q  <= word_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  mem_lane_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .split_i     (word_q & addr_q[0]),
    .bus_ready_i (bus_ready_i),
    .latch_o     (latch),
    .second_o    (second),
    .bus_req_o   (bus_req_o),
    .cap_o       (cap),
    .ack_o       (ack_o)
  );

  mem_lane_steer #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_steer (
    .active_i    (bus_req_o),
    .second_i    (second),
    .we_i        (we_q),
    .word_i      (word_q),
    .addr_i      (addr_q),
    .wdata_i     (wdata_q),
    .bus_addr_o  (bus_addr_o),
    .bus_be_o    (bus_be_o),
    .bus_we_o    (bus_we_o),
    .bus_wdata_o (bus_wdata_o)
  );

  mem_lane_merge #(.LANE_W(LANE_W)) u_merge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_i       (cap),
    .second_i    (second),
    .we_i        (we_q),
    .word_i      (word_q),
    .odd_i       (addr_q[0]),
    .bus_rdata_i (bus_rdata_i),
    .rdata_o     (rdata_o)
  );
endmodule

// File: rtl/mem_lane_bridge_chk.sv
module mem_lane_bridge_chk #(
  parameter int ADDR_W = 20,
  parameter int DW     = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_o,
  input logic              bus_req_o,
  input logic              bus_ready_i,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [1:0]        bus_be_o,
  input logic [DW-1:0]     bus_wdata_o
);
  AST_IDLE_LANES_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_o |-> (bus_be_o == 2'b00) && !bus_we_o); // R9

  AST_LANE_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_be_o != 2'b00)); // R2

  AST_HOLD_WHILE_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ready_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_be_o)
      && $stable(bus_we_o) && $stable(bus_wdata_o)); // R7

  AST_SPLIT_NEXT_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && (bus_be_o == 2'b01) && $past(bus_req_o && bus_ready_i)
      |-> (bus_addr_o == $past(bus_addr_o) + 1'b1) && ($past(bus_be_o) == 2'b10)); // R3

  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R8

  AST_ACK_AFTER_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !bus_req_o && $past(bus_req_o && bus_ready_i)); // R8
endmodule

bind mem_lane_bridge mem_lane_bridge_chk #(.ADDR_W(ADDR_W), .DW(2*LANE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ack_o       (ack_o),
  .bus_req_o   (bus_req_o),
  .bus_ready_i (bus_ready_i),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_be_o    (bus_be_o),
  .bus_wdata_o (bus_wdata_o)
);

// File: tb/mem_lane_bridge_test.sv
module mem_lane_bridge_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, word_i = 1'b0;
  logic [19:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        ack_o;
  logic [15:0] rdata_o;
  logic        bus_req_o, bus_we_o;
  logic [19:0] bus_addr_o;
  logic [1:0]  bus_be_o;
  logic [15:0] bus_wdata_o;
  logic [15:0] bus_rdata_i;
  logic        bus_ready_i = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  mem_lane_bridge uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .word_i(word_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ack_o(ack_o), .rdata_o(rdata_o),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_be_o(bus_be_o), .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i),
    .bus_ready_i(bus_ready_i)
  );

  function automatic logic [7:0] byte_at(input logic [19:0] a);
    return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'hA5;
  endfunction

  // memory responder: each lane carries its own address-dependent byte
  assign bus_rdata_i = {byte_at({bus_addr_o[19:1], 1'b1}), byte_at({bus_addr_o[19:1], 1'b0})};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus log and wait control
  int          cur_waits = 0;
  int          wcnt = 0;
  bit          prev_wait = 0;
  int          log_n = 0;
  logic [19:0] log_addr [4];
  logic [1:0]  log_be   [4];
  logic [15:0] log_wd   [4];
  logic        log_we   [4];
  logic [19:0] h_addr;
  logic [1:0]  h_be;
  logic [15:0] h_wd;
  logic        h_we;

  always @(negedge clk_i) begin
    if (rst_ni && bus_req_o) begin
      if (prev_wait)  // R7 outputs held while ready was low
        chk(bus_addr_o == h_addr && bus_be_o == h_be && bus_wdata_o == h_wd && bus_we_o == h_we,
            "R7 hold", {bus_be_o, bus_wdata_o}, {h_be, h_wd});
      if (wcnt < cur_waits) begin
        bus_ready_i = 1'b0;
        wcnt++;
        prev_wait = 1;
        h_addr = bus_addr_o; h_be = bus_be_o; h_wd = bus_wdata_o; h_we = bus_we_o;
      end else begin
        bus_ready_i = 1'b1;
        wcnt = 0;
        prev_wait = 0;
        if (log_n < 4) begin
          log_addr[log_n] = bus_addr_o; log_be[log_n] = bus_be_o;
          log_wd[log_n] = bus_wdata_o; log_we[log_n] = bus_we_o;
        end
        log_n++;
      end
    end else begin
      bus_ready_i = 1'b0;
      wcnt = 0;
      prev_wait = 0;
    end
  end

  typedef struct packed {
    logic        we;
    logic        word;
    logic [19:0] addr;
    logic [15:0] wdata;
    logic [1:0]  waits;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 20'h00010, 16'h0000, 2'd0},
    '{1'b0, 1'b0, 20'h00011, 16'h0000, 2'd1},
    '{1'b0, 1'b1, 20'h12344, 16'h0000, 2'd0},
    '{1'b0, 1'b1, 20'h12345, 16'h0000, 2'd2},
    '{1'b1, 1'b0, 20'h3A0C2, 16'hBE5A, 2'd0},
    '{1'b1, 1'b0, 20'h3A0C3, 16'h77C1, 2'd1},
    '{1'b1, 1'b1, 20'h40000, 16'hD00F, 2'd0},
    '{1'b1, 1'b1, 20'h0ABCF, 16'h9E21, 2'd0},
    '{1'b0, 1'b1, 20'hFFFFF, 16'h0000, 2'd1},
    '{1'b1, 1'b1, 20'hFFFFF, 16'h4C83, 2'd3}
  };

  task automatic run_vec(input vec_t v);
    int          lat;
    int          n_exp;
    logic [1:0]  be0;
    logic [19:0] a1;
    logic [15:0] exp_rd;
    logic [7:0]  b0;
    bit          split;
    split  = v.word & v.addr[0];
    n_exp  = split ? 2 : 1;
    a1     = v.addr + 20'd1;
    be0    = v.word ? (v.addr[0] ? 2'b10 : 2'b11) : (v.addr[0] ? 2'b10 : 2'b01);
    exp_rd = v.word ? {byte_at(a1), byte_at(v.addr)} : {8'h00, byte_at(v.addr)};

    @(negedge clk_i);
    cur_waits = int'(v.waits);
    log_n = 0;
    req_i = 1'b1; we_i = v.we; word_i = v.word; addr_i = v.addr; wdata_i = v.wdata;
    lat = 0;
    do begin
      @(negedge clk_i);
      lat++;
    end while (!ack_o && lat < 60);
    req_i = 1'b0;

    chk(ack_o, "R8 ack seen", 32'(ack_o), 1);
    chk(lat == n_exp * (1 + int'(v.waits)) + 1, "R8 latency", lat, n_exp * (1 + int'(v.waits)) + 1);
    chk(bus_be_o == 2'b00 && !bus_we_o, "R9 idle lanes", {bus_be_o, bus_we_o}, 0);
    chk(log_n == n_exp, "R3 bus cycle count", log_n, n_exp);
    if (log_n >= 1) begin
      chk(log_addr[0] == v.addr, "R2 first address", log_addr[0], v.addr);
      chk(log_be[0] == be0, "R2 first enables", log_be[0], be0);
      chk(log_we[0] == v.we, "R9 write flag", log_we[0], v.we);
    end
    if (split && log_n >= 2) begin
      chk(log_addr[1] == a1, "R3 second address", log_addr[1], a1);
      chk(log_be[1] == 2'b01, "R3 second enables", log_be[1], 2'b01);
    end
    if (v.we) begin
      if (v.word && !v.addr[0]) begin
        chk(log_wd[0] == v.wdata, "R6 even word data", log_wd[0], v.wdata);
      end else begin
        b0 = v.wdata[7:0];
        chk(log_wd[0] == {b0, b0}, "R6 low byte both lanes", log_wd[0], {b0, b0});
        if (split && log_n >= 2)
          chk(log_wd[1] == {v.wdata[15:8], v.wdata[15:8]}, "R6 high byte both lanes",
              log_wd[1], {v.wdata[15:8], v.wdata[15:8]});
      end
    end else begin
      chk(rdata_o == exp_rd, v.word ? "R5 word read" : "R4 byte read", rdata_o, exp_rd);
    end
    @(negedge clk_i);
    chk(!ack_o, "R8 single pulse", 32'(ack_o), 0);
  endtask

  initial begin
    #1;
    chk(!ack_o && !bus_req_o && bus_be_o == 2'b00, "R1 in reset", {ack_o, bus_req_o, bus_be_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!ack_o && !bus_req_o && bus_be_o == 2'b00, "R1 after reset", {ack_o, bus_req_o, bus_be_o}, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // reset during a stalled bus cycle aborts it
    @(negedge clk_i);
    cur_waits = 3;
    req_i = 1'b1; we_i = 1'b1; word_i = 1'b1; addr_i = 20'h00101; wdata_i = 16'h1234;
    @(negedge clk_i);
    req_i = 1'b0;
    chk(bus_req_o, "R7 stalled cycle active", 32'(bus_req_o), 1);
    rst_ni = 1'b0;
    #1;
    chk(!bus_req_o && !ack_o && bus_be_o == 2'b00, "R1 reset aborts", {bus_req_o, ack_o, bus_be_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!bus_req_o && !ack_o, "R1 stays idle", {bus_req_o, ack_o}, 0);

    // back-to-back after abort still works
    run_vec('{1'b0, 1'b1, 20'h00203, 16'h0000, 2'd0});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule